// File: doc/BRIEF.md
# Analog-Shared GPIO Port Controller

This block controls an 8-pin general-purpose I/O port whose pins are also used by an analog converter and a keyboard wake-up function. It holds a data register and a direction register, both reached over a simple register bus made of an address, a write strobe, write data and combinational read data. For each pin it produces an output enable and an output level for the pad. It samples the pad levels through a two-flop synchronizer so they can be read back.

Ownership of each pin follows a fixed priority. The converter comes first, then wake-up, then plain I/O. The two higher functions claim a pin through per-pin claim inputs. A claimed pin never has its GPIO driver enabled.

A per-pin digital-input-enable vector comes from the converter. It decides what an input pin reads back. With the buffer off, an input pin reads a constant 1. With the buffer on, it reads the synchronized pad level. An output pin always reads back its stored register bit. After reset every pin is an undriven input with its digital buffer off.

The bus and the pin vectors are plain control signals that are sampled every cycle, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `shared_port_ctrl`

## Requirements
- R1: After reset the data and direction registers are 00h and `pad_oe` is 00h. A read of the data address with `dien` = 00h returns FFh.
- R2: A write to the data address (BASE, default 0) is always stored, whatever the direction. `pad_out` carries the stored byte.
- R3: `pad_oe[i]` is 1 only when direction bit i is 1 and neither claim input for pin i is set.
- R4: When direction bit i is 1, read bit i of the data address returns the stored data bit, whatever `dien[i]` or the pad level is.
- R5: When direction bit i is 0 and `dien[i]` is 0, read bit i of the data address returns 1.
- R6: When direction bit i is 0 and `dien[i]` is 1, read bit i returns the pad level. A pad change driven between two edges appears in the read data after the second rising edge, and not after the first.
- R7: `pin_owner[2i+1:2i]` names the owner of pin i. The value 2 means converter, given when `adc_claim[i]` is set. The value 1 means wake-up, given when only `kwu_claim[i]` is set. The value 0 means GPIO, given when neither claim is set. The value 3 never occurs.
- R8: A converter or wake-up claim on pin i forces `pad_oe[i]` to 0, even when direction bit i is 1.
- R9: Writes to addresses other than BASE and BASE+1 change no register. Reads from those addresses return 00h.
- R10: A write to the direction address (BASE+1, default 1) is stored, and a read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| dien | input | 8 | Per-pin digital input enable from the converter |
| adc_claim | input | 8 | Per-pin claim by the converter (highest priority) |
| kwu_claim | input | 8 | Per-pin claim by wake-up (second priority) |
| pad_in | input | 8 | Pad levels (asynchronous) |
| pad_oe | output | 8 | Per-pin GPIO output enable |
| pad_out | output | 8 | Per-pin GPIO output level |
| pin_owner | output | 16 | Two-bit owner code per pin |

## Verification
The read path is exercised with direction set to all inputs, to all outputs, and to a mixed byte combined with a mixed enable vector and a pad byte chosen so that each of the three read sources shows up in a different bit. This separates a stored-bit return from a pad return and from the constant 1. A pad change is read back after one edge and again after two, which tells a correct two-stage synchronizer from a missing or extra stage. Claim patterns overlap on some pins and fall alone on others, so a wrong priority order in the owner code or in the enable gating shows up. Writes to an unmapped address are followed by read-back of both registers.

// File: rtl/shared_port_pkg.sv
package shared_port_pkg;
  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_WAKE = 2'd1,
    OWN_CONV = 2'd2
  } owner_e;

  function automatic owner_e pick_owner(input logic conv, input logic wake);
    if (conv)      return OWN_CONV;
    else if (wake) return OWN_WAKE;
    else           return OWN_GPIO;
  endfunction
endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int                W      = 8,
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic              hit_data,
  output logic              hit_dir,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE;
  localparam logic [ADDR_W-1:0] DIR_ADDR  = BASE + 1'b1;

  assign hit_data = (addr == DATA_ADDR);
  assign hit_dir  = (addr == DIR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      if (hit_data) data_q <= wdata;
      if (hit_dir)  dir_q  <= wdata;
    end
  end
endmodule

// File: rtl/port_pin_slice.sv
module port_pin_slice
  import shared_port_pkg::*;
(
  input  logic       dir_bit,
  input  logic       data_bit,
  input  logic       dien_bit,
  input  logic       pin_sync,
  input  logic       conv_claim,
  input  logic       wake_claim,
  output logic       oe,
  output logic       out,
  output logic       rd_bit,
  output logic [1:0] owner
);
  owner_e who;

  always_comb begin
    who = pick_owner(conv_claim, wake_claim);
    oe  = dir_bit && (who == OWN_GPIO);
    out = data_bit;
    if (dir_bit)       rd_bit = data_bit;
    else if (dien_bit) rd_bit = pin_sync;
    else               rd_bit = 1'b1;
  end

  assign owner = who;
endmodule

// File: rtl/shared_port_ctrl.sv
module shared_port_ctrl #(
  parameter int                W      = 8,
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      dien,
  input  logic [W-1:0]      adc_claim,
  input  logic [W-1:0]      kwu_claim,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [2*W-1:0]    pin_owner
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_s;
  logic [W-1:0] rd_vec;
  logic         hit_data;
  logic         hit_dir;

  port_regs #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .hit_data (hit_data),
    .hit_dir  (hit_dir),
    .data_q   (data_q),
    .dir_q    (dir_q)
  );

  port_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_s)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    port_pin_slice u_slice (
      .dir_bit    (dir_q[i]),
      .data_bit   (data_q[i]),
      .dien_bit   (dien[i]),
      .pin_sync   (pin_s[i]),
      .conv_claim (adc_claim[i]),
      .wake_claim (kwu_claim[i]),
      .oe         (pad_oe[i]),
      .out        (pad_out[i]),
      .rd_bit     (rd_vec[i]),
      .owner      (pin_owner[2*i +: 2])
    );
  end

  always_comb begin
    if (hit_data)     bus_rdata = rd_vec;
    else if (hit_dir) bus_rdata = dir_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/shared_port_ctrl_chk.sv
module shared_port_ctrl_chk #(
  parameter int                W      = 8,
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      dien,
  input logic [W-1:0]      adc_claim,
  input logic [W-1:0]      kwu_claim,
  input logic [W-1:0]      pad_oe,
  input logic [2*W-1:0]    pin_owner,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      dir_q
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = BASE + 1'b1;

  logic [W-1:0] owner_bad;
  always_comb begin
    for (int i = 0; i < W; i++) begin
      owner_bad[i] = (pin_owner[2*i +: 2] == 2'd3)
                  || (adc_claim[i] && pin_owner[2*i +: 2] != 2'd2)
                  || (!adc_claim[i] && !kwu_claim[i] && pin_owner[2*i +: 2] != 2'd0);
    end
  end

  logic unmapped;
  assign unmapped = (bus_addr != BASE) && (bus_addr != DIR_ADDR);

  // R2
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == BASE) |=> (data_q == $past(bus_wdata)));

  // R10
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR) |=> (dir_q == $past(bus_wdata)));

  // R8
  claim_blocks_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & (adc_claim | kwu_claim)) == '0));

  // R3
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q) == '0));

  // R7
  owner_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_bad == '0));

  // R5
  input_off_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == BASE && dir_q == '0 && dien == '0) |-> (bus_rdata == '1));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(data_q) && $stable(dir_q)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));
endmodule

bind shared_port_ctrl shared_port_ctrl_chk #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .dien      (dien),
  .adc_claim (adc_claim),
  .kwu_claim (kwu_claim),
  .pad_oe    (pad_oe),
  .pin_owner (pin_owner),
  .data_q    (data_q),
  .dir_q     (dir_q)
);

// File: tb/tb_shared_port_ctrl.sv
`timescale 1ns/1ps
module tb_shared_port_ctrl;
  localparam logic [3:0] A_DATA = 4'd0;
  localparam logic [3:0] A_DIR  = 4'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  dien = '0;
  logic [7:0]  adc_claim = '0;
  logic [7:0]  kwu_claim = '0;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_out;
  logic [15:0] pin_owner;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shared_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dien(dien),
    .adc_claim(adc_claim), .kwu_claim(kwu_claim), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pin_owner(pin_owner)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Model of the read path from R4, R5, R6
  function automatic logic [7:0] exp_read(input logic [7:0] dir, input logic [7:0] dat,
                                          input logic [7:0] en, input logic [7:0] pin);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = dir[i] ? dat[i] : (en[i] ? pin[i] : 1'b1);
    return r;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    rd(A_DATA, d); check("R1 data read after reset", d, 8'hFF);
    rd(A_DIR, d);  check("R1 dir after reset", d, 8'h00);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 pad_out after reset", pad_out, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [7:0] d;
    wr(A_DIR, 8'hA5);
    rd(A_DIR, d); check("R10 dir readback", d, 8'hA5);
    wr(A_DIR, 8'h00);
    rd(A_DIR, d); check("R10 dir cleared", d, 8'h00);
  endtask

  task automatic t_store_as_input();
    logic [7:0] d;
    dien = 8'h00;
    wr(A_DATA, 8'h3C);
    check("R2 pad_out holds stored byte", pad_out, 8'h3C);
    check("R3 no drive while input", pad_oe, 8'h00);
    rd(A_DATA, d); check("R5 input with buffer off reads 1", d, 8'hFF);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, d); check("R2 stored while input, seen as output", d, 8'h3C);
    check("R3 drive when output", pad_oe, 8'hFF);
  endtask

  task automatic t_output_ignores_pin();
    logic [7:0] d;
    wr(A_DIR, 8'hFF);
    wr(A_DATA, 8'h96);
    dien = 8'hFF; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(A_DATA, d); check("R4 output reads register not pin (dien on)", d, 8'h96);
    pad_in = 8'hFF; dien = 8'h00;
    repeat (3) @(negedge clk);
    rd(A_DATA, d); check("R4 output reads register not pin (dien off)", d, 8'h96);
  endtask

  task automatic t_input_sync();
    logic [7:0] d;
    wr(A_DIR, 8'h00);
    dien = 8'hFF; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(A_DATA, d); check("R6 settled pin low", d, 8'h00);
    pad_in = 8'h5A;
    @(negedge clk);
    rd(A_DATA, d); check("R6 one edge after pad change: old value", d, 8'h00);
    @(negedge clk);
    rd(A_DATA, d); check("R6 two edges after pad change: new value", d, 8'h5A);
  endtask

  task automatic t_mixed();
    logic [7:0] d;
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'hAA);
    dien = 8'h33; pad_in = 8'hC6;
    repeat (3) @(negedge clk);
    rd(A_DATA, d);
    check("R4 R5 R6 mixed read", d, exp_read(8'h0F, 8'hAA, 8'h33, 8'hC6));
    check("R3 mixed drive", pad_oe, 8'h0F);
  endtask

  task automatic t_claims();
    logic [15:0] eo;
    wr(A_DIR, 8'hFF);
    adc_claim = 8'h03; kwu_claim = 8'h06;
    #1;
    check("R8 claims force oe low", pad_oe, 8'hF8);
    for (int i = 0; i < 8; i++)
      eo[2*i +: 2] = adc_claim[i] ? 2'd2 : (kwu_claim[i] ? 2'd1 : 2'd0);
    check("R7 owner codes", pin_owner, eo);
    adc_claim = 8'h80; kwu_claim = 8'h81;
    #1;
    check("R8 claims on pin 0 and 7", pad_oe, 8'h7E);
    check("R7 converter outranks wake-up", pin_owner, 16'h8001);
    adc_claim = '0; kwu_claim = '0;
    #1;
    check("R3 drive restored after claims drop", pad_oe, 8'hFF);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(A_DIR, 8'h0F);
    wr(A_DATA, 8'h55);
    wr(4'd5, 8'hFF);
    wr(4'd15, 8'h00);
    rd(A_DIR, d);  check("R9 dir unchanged by unmapped write", d, 8'h0F);
    check("R9 data unchanged by unmapped write", pad_out, 8'h55);
    rd(4'd5, d);   check("R9 unmapped read zero", d, 8'h00);
    rd(4'd2, d);   check("R9 unmapped read zero at 2", d, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_rw();
    t_store_as_input();
    t_output_ignores_pin();
    t_input_sync();
    t_mixed();
    t_claims();
    t_map();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule